// File: doc/BRIEF.md
# Conditional Vector Step Sequencer

This block runs a burst of steps taken from a small step table. Each step selects a contiguous block of vector addresses (a start offset and a count), the period of its system clock in half-master-clock units, and how many system clocks make one vector clock. As the step runs, the block emits each vector address together with a strobe at the start of that vector, plus an enable pulse for every system-clock period.

When the last vector of a step completes, the step's control statement is evaluated against a selected condition: step pass or fail, burst pass or fail, or one of four control-resource bits, in true or inverted form. The action may jump, call a subroutine (return index pushed on a four-deep stack), return, repeat the step under a loop counter, stop, or fall through to the next step. The burst ends when a last-flagged step falls through, when a stop is taken, or on an error. An error is a step with illegal parameters, a call with a full stack, or a return with an empty stack.

Top module: `cond_step_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err, vec_stb and sys_ce are 0 and step_idx is 0.
- R2: A start pulse while idle runs the burst from step 0. Each step strobes the addresses offset, offset+1, ... offset+count-1 in turn, with step_idx showing the running step. A step entry is packed MSB first as {offset[11:0], count[7:0], period[16:0], cpv[1:0], last, op[2:0], cond[3:0], target[3:0], loops[3:0]} and written through wr_en/wr_idx/wr_step.
- R3: Within a step, sys_ce pulses once every period/2 clock cycles. Each vector lasts cpv*period/2 cycles, so it spans exactly cpv sys_ce pulses. vec_stb coincides with the first of them.
- R4: A step is legal only if offset is a multiple of 4, period is even and within 20..65550, cpv is 1..3 and count is at least 1. An illegal step emits no strobe and ends the burst with done and err set.
- R5: The cond codes are 0 always, 1 step pass, 2 not step pass, 3 step fail, 4 not step fail, 5 burst pass, 6 burst fail, 7..10 control resource 0..3 high, 11..14 control resource 0..3 low, 15 never. The condition is evaluated only once the step's vectors are finished.
- R6: op 0 (next), and any op whose condition is false, goes to the following step. On a last-flagged step this instead ends the burst with done and err clear. op codes 6 and 7 behave as op 0.
- R7: op 1 (jump) with a true condition continues at step target.
- R8: op 2 (call) with a true condition pushes the index of the following step and continues at target. A call while four returns are already stacked ends the burst with err set.
- R9: op 5 (return) with a true condition continues at the popped index. With an empty stack it ends the burst with err set.
- R10: op 3 (loop) reloads its counter from loops when the step is entered from elsewhere. The step repeats, decrementing the counter, while the counter is nonzero and the condition is true.
- R11: op 4 (stop) with a true condition ends the burst with err clear, whatever the last flag says.
- R12: A start pulse while busy has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write one step entry |
| wr_idx | input | 4 | Step index written |
| wr_step | input | 55 | Packed step entry |
| start | input | 1 | Begin a burst when idle |
| step_pass | input | 1 | Step passed |
| step_fail | input | 1 | Step failed |
| burst_pass | input | 1 | Burst passed |
| burst_fail | input | 1 | Burst failed |
| ctl_res | input | 4 | Control-resource bits |
| vec_addr | output | 12 | Current vector address |
| vec_stb | output | 1 | Start of a vector |
| sys_ce | output | 1 | One pulse per system-clock period |
| step_idx | output | 4 | Running step |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when a burst ends |
| err | output | 1 | Last burst ended on an error |

## Verification
A loop statement on a last-flagged step makes two decisions in one evaluation cycle: whether to repeat and whether to end the burst. A repeat must win while its counter is nonzero, and the burst must end in the same evaluation that finds the counter spent. The bench provokes this with a looping final step placed behind another looping step, so the counter reload on entry is also exercised. It judges the result by the exact number of times the last step's address block appears in the strobe trace. A second overlap, a fresh start pulse while a step is already emitting vectors, is judged by comparing the trace with the one expected from the single start.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int VA_W  = 12;
  parameter int CNT_W = 8;
  parameter int PER_W = 17;
  parameter int CPV_W = 2;
  parameter int SI_W  = 4;
  parameter int LC_W  = 4;
  parameter int STK_D = 4;
  localparam int N_STEPS = 1 << SI_W;
  localparam int PER_MIN = 20;
  localparam int PER_MAX = 65550;
  localparam int HALF_W  = PER_W - 1;

  localparam logic [2:0] OP_NEXT = 3'd0;
  localparam logic [2:0] OP_JUMP = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_LOOP = 3'd3;
  localparam logic [2:0] OP_STOP = 3'd4;
  localparam logic [2:0] OP_RET  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_EVAL} st_e;

  typedef struct packed {
    logic [VA_W-1:0]  offset;
    logic [CNT_W-1:0] count;
    logic [PER_W-1:0] period;
    logic [CPV_W-1:0] cpv;
    logic             last;
    logic [2:0]       op;
    logic [3:0]       cond;
    logic [SI_W-1:0]  target;
    logic [LC_W-1:0]  loops;
  } step_t;

  localparam int STEP_W = $bits(step_t);

  function automatic logic step_legal(step_t s);
    return (s.offset[1:0] == 2'b00) && !s.period[0] &&
           (s.period >= PER_W'(PER_MIN)) && (s.period <= PER_W'(PER_MAX)) &&
           (s.cpv != '0) && (s.count != '0);
  endfunction

  function automatic logic [HALF_W-1:0] half_of(logic [PER_W-1:0] p);
    return p[PER_W-1:1];
  endfunction

  function automatic logic cond_true(logic [3:0] c, logic sp, logic sf,
                                     logic bp, logic bf, logic [3:0] res);
    logic r;
    case (c)
      4'd0:  r = 1'b1;
      4'd1:  r = sp;
      4'd2:  r = !sp;
      4'd3:  r = sf;
      4'd4:  r = !sf;
      4'd5:  r = bp;
      4'd6:  r = bf;
      4'd15: r = 1'b0;
      default: begin
        if (c < 4'd11) r = res[c[1:0] + 2'd1];
        else           r = !res[c[1:0] + 2'd1];
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seq_pacer.sv
module seq_pacer
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  input  logic [CPV_W-1:0]  cpv,
  output logic              sys_ce,
  output logic              vec_begin,
  output logic              vec_end
);
  logic [HALF_W-1:0] sc;
  logic [CPV_W-1:0]  k;
  logic              sc_wrap;
  logic              k_wrap;

  assign sc_wrap = (sc == half - 1'b1);
  assign k_wrap  = (k == cpv - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc <= '0;
      k  <= '0;
    end else if (!run) begin
      sc <= '0;
      k  <= '0;
    end else if (sc_wrap) begin
      sc <= '0;
      k  <= k_wrap ? '0 : k + 1'b1;
    end else begin
      sc <= sc + 1'b1;
    end
  end

  assign sys_ce    = run && (sc == '0);
  assign vec_begin = sys_ce && (k == '0);
  assign vec_end   = run && sc_wrap && k_wrap;
endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int W = 4,
  parameter int D = 4,
  localparam int PW = $clog2(D + 1),
  localparam int IW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [PW-1:0] depth
);
  logic [W-1:0]  slots [D];
  logic [PW-1:0] ptr;
  logic [PW-1:0] top_p;

  assign top_p = ptr - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clear) begin
      ptr <= '0;
    end else if (push && !full) begin
      ptr <= ptr + 1'b1;
    end else if (pop && !empty) begin
      ptr <= top_p;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clear) slots[IW'(ptr)] <= din;
  end

  assign full  = (ptr == PW'(D));
  assign empty = (ptr == '0);
  assign depth = ptr;
  assign dout  = empty ? '0 : slots[IW'(top_p)];
endmodule

// File: rtl/seq_branch.sv
module seq_branch
  import seq_pkg::*;
(
  input  logic [2:0]      op,
  input  logic            ok,
  input  logic            last,
  input  logic [SI_W-1:0] idx,
  input  logic [SI_W-1:0] target,
  input  logic            loop_nz,
  input  logic            stk_full,
  input  logic            stk_empty,
  input  logic [SI_W-1:0] stk_top,
  output logic [SI_W-1:0] nxt_idx,
  output logic            fin,
  output logic            fault,
  output logic            push,
  output logic            pop,
  output logic            repeat_step
);
  always_comb begin
    nxt_idx     = idx + 1'b1;
    fin         = last;
    fault       = 1'b0;
    push        = 1'b0;
    pop         = 1'b0;
    repeat_step = 1'b0;
    if (ok) begin
      case (op)
        OP_JUMP: begin
          nxt_idx = target;
          fin     = 1'b0;
        end
        OP_CALL: begin
          if (stk_full) fault = 1'b1;
          else begin
            push    = 1'b1;
            nxt_idx = target;
            fin     = 1'b0;
          end
        end
        OP_LOOP: begin
          if (loop_nz) begin
            nxt_idx     = idx;
            fin         = 1'b0;
            repeat_step = 1'b1;
          end
        end
        OP_STOP: fin = 1'b1;
        OP_RET: begin
          if (stk_empty) fault = 1'b1;
          else begin
            pop     = 1'b1;
            nxt_idx = stk_top;
            fin     = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cond_step_seq.sv
module cond_step_seq
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SI_W-1:0]   wr_idx,
  input  logic [STEP_W-1:0] wr_step,
  input  logic              start,
  input  logic              step_pass,
  input  logic              step_fail,
  input  logic              burst_pass,
  input  logic              burst_fail,
  input  logic [3:0]        ctl_res,
  output logic [VA_W-1:0]   vec_addr,
  output logic              vec_stb,
  output logic              sys_ce,
  output logic [SI_W-1:0]   step_idx,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int DW = $clog2(STK_D + 1);

  step_t             table_q [N_STEPS];
  step_t             cur;
  step_t             fetched;
  st_e               st;
  logic [SI_W-1:0]   idx;
  logic [VA_W-1:0]   vaddr;
  logic [CNT_W-1:0]  vleft;
  logic [LC_W-1:0]   loopc;
  logic              entry;
  logic              done_q;
  logic              err_q;

  // named internal events for the checker
  logic              in_run;
  logic              in_eval;
  logic              cur_ok;
  logic              vec_end;
  logic              vec_begin;
  logic              cond_ok;
  logic [DW-1:0]     stk_depth;

  logic [SI_W-1:0]   br_idx;
  logic              br_fin, br_fault, br_push, br_pop, br_rep;
  logic              stk_full, stk_empty;
  logic [SI_W-1:0]   stk_top;

  always_ff @(posedge clk) begin
    if (wr_en) table_q[wr_idx] <= step_t'(wr_step);
  end

  assign fetched = table_q[idx];
  assign in_run  = (st == S_RUN);
  assign in_eval = (st == S_EVAL);
  assign cur_ok  = step_legal(cur);
  assign cond_ok = cond_true(cur.cond, step_pass, step_fail, burst_pass,
                             burst_fail, ctl_res);

  seq_pacer u_pacer (
    .clk(clk), .rst_n(rst_n), .run(in_run),
    .half(half_of(cur.period)), .cpv(cur.cpv),
    .sys_ce(sys_ce), .vec_begin(vec_begin), .vec_end(vec_end)
  );

  seq_stack #(.W(SI_W), .D(STK_D)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .clear(st == S_IDLE && start),
    .push(in_eval && br_push), .pop(in_eval && br_pop),
    .din(idx + 1'b1), .dout(stk_top),
    .full(stk_full), .empty(stk_empty), .depth(stk_depth)
  );

  seq_branch u_branch (
    .op(cur.op), .ok(cond_ok), .last(cur.last), .idx(idx),
    .target(cur.target), .loop_nz(loopc != '0),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_top(stk_top),
    .nxt_idx(br_idx), .fin(br_fin), .fault(br_fault),
    .push(br_push), .pop(br_pop), .repeat_step(br_rep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      cur    <= '0;
      vaddr  <= '0;
      vleft  <= '0;
      loopc  <= '0;
      entry  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_LOAD;
          idx   <= '0;
          entry <= 1'b1;
          err_q <= 1'b0;
        end
        S_LOAD: begin
          cur <= fetched;
          if (!step_legal(fetched)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st    <= S_RUN;
            vaddr <= fetched.offset;
            vleft <= fetched.count;
            if (entry) loopc <= fetched.loops;
            entry <= 1'b0;
          end
        end
        S_RUN: if (vec_end) begin
          if (vleft == CNT_W'(1)) st <= S_EVAL;
          else begin
            vleft <= vleft - 1'b1;
            vaddr <= vaddr + 1'b1;
          end
        end
        S_EVAL: begin
          if (br_fault || br_fin) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= br_fault;
          end else begin
            st    <= S_LOAD;
            idx   <= br_idx;
            entry <= !br_rep;
            if (br_rep) loopc <= loopc - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign vec_addr = vaddr;
  assign vec_stb  = vec_begin;
  assign step_idx = idx;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import seq_pkg::*;
#(
  localparam int DW = $clog2(STK_D + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            vec_stb,
  input logic            sys_ce,
  input logic            in_run,
  input logic            cur_ok,
  input logic [VA_W-1:0] vaddr,
  input logic [DW-1:0]   stk_depth
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vec_stb && !sys_ce));  // R1

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && $past(in_run) && !$stable(vaddr)) |-> (vaddr == $past(vaddr) + 1'b1));  // R2

  AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ce |=> !sys_ce);  // R3

  AST_LEGAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> cur_ok);  // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    stk_depth <= DW'(STK_D));  // R8
endmodule

bind cond_step_seq seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .vec_stb(vec_stb), .sys_ce(sys_ce), .in_run(in_run), .cur_ok(cur_ok),
  .vaddr(vaddr), .stk_depth(stk_depth)
);

// File: tb/sim_cond_step_seq.sv
module sim_cond_step_seq;
  import seq_pkg::*;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SI_W-1:0] wr_idx = '0;
  logic [STEP_W-1:0] wr_step = '0;
  logic start = 1'b0, step_pass = 1'b0, step_fail = 1'b0;
  logic burst_pass = 1'b0, burst_fail = 1'b0;
  logic [3:0] ctl_res = '0;
  logic [VA_W-1:0] vec_addr;
  logic vec_stb, sys_ce, busy, done, err;
  logic [SI_W-1:0] step_idx;

  always #(CLK_NS/2) clk = ~clk;

  cond_step_seq u0 (.*);

  step_t prog [N_STEPS];
  int n_chk = 0, n_err = 0;
  int e_addr[$], e_idx[$], e_per[$], e_cpv[$];
  bit e_first[$];
  bit e_err, e_valid;
  int a_addr[$], a_idx[$], a_iv[$], a_ce[$];
  int cyc = 0, last_cyc = 0, ce_run = 0;
  bit mon_on = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (vec_stb) begin
        a_addr.push_back(int'(vec_addr));
        a_idx.push_back(int'(step_idx));
        a_iv.push_back(cyc - last_cyc);
        a_ce.push_back(ce_run);
        last_cyc = cyc;
        ce_run = 1;
      end else if (sys_ce) ce_run++;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic step_t mk(int off, int cnt, int per, int cpv, bit last,
                               int op, int cond, int tgt, int loops);
    step_t s;
    s.offset = VA_W'(off);  s.count = CNT_W'(cnt); s.period = PER_W'(per);
    s.cpv = CPV_W'(cpv);    s.last = last;         s.op = 3'(op);
    s.cond = 4'(cond);      s.target = SI_W'(tgt); s.loops = LC_W'(loops);
    return s;
  endfunction

  task automatic put(int i, step_t s);
    prog[i] = s;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = SI_W'(i); wr_step = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // reference model of one burst, written from the requirements
  task automatic model(bit sp, bit sf, bit bp, bit bf, logic [3:0] rs);
    int idx = 0, lc = 0, sd = 0, guard = 0;
    int stk[4];
    bit entry = 1;
    bit [15:0] truth;
    e_addr.delete(); e_idx.delete(); e_per.delete(); e_cpv.delete(); e_first.delete();
    e_err = 0; e_valid = 1;
    truth = {1'b0, ~rs, rs, bf, bp, ~sf, sf, ~sp, sp, 1'b1};
    forever begin
      step_t s = prog[idx];
      int nidx = (idx + 1) % N_STEPS;
      bit fin = s.last, fault = 0, ent = 1, ok;
      guard++;
      if (guard > 300) begin e_valid = 0; break; end
      if ((s.offset % 4) != 0 || (s.period % 2) != 0 || s.period < 20 ||
          s.period > 65550 || s.cpv == 0 || s.count == 0) begin
        e_err = 1; break;
      end
      if (entry) lc = int'(s.loops);
      for (int v = 0; v < int'(s.count); v++) begin
        e_addr.push_back((int'(s.offset) + v) % (1 << VA_W));
        e_idx.push_back(idx);
        e_per.push_back(int'(s.cpv) * (int'(s.period) / 2));
        e_cpv.push_back(int'(s.cpv));
        e_first.push_back(v == 0);
      end
      ok = truth[s.cond];
      if (ok && s.op == 1) begin nidx = int'(s.target); fin = 0; end
      if (ok && s.op == 2) begin
        if (sd == 4) fault = 1;
        else begin stk[sd] = (idx + 1) % N_STEPS; sd++; nidx = int'(s.target); fin = 0; end
      end
      if (ok && s.op == 3 && lc != 0) begin lc--; nidx = idx; fin = 0; ent = 0; end
      if (ok && s.op == 4) fin = 1;
      if (ok && s.op == 5) begin
        if (sd == 0) fault = 1;
        else begin sd--; nidx = stk[sd]; fin = 0; end
      end
      if (fault) begin e_err = 1; break; end
      if (fin) break;
      idx = nidx; entry = ent;
    end
  endtask

  task automatic run_burst(string req, bit sp, bit sf, bit bp, bit bf,
                           logic [3:0] rs, bit poke);
    int bad = 0, first_bad = -1, tmo = 0;
    model(sp, sf, bp, bf, rs);
    if (!e_valid) return;
    @(negedge clk);
    step_pass = sp; step_fail = sf; burst_pass = bp; burst_fail = bf; ctl_res = rs;
    a_addr.delete(); a_idx.delete(); a_iv.delete(); a_ce.delete();
    mon_on = 1; last_cyc = cyc; ce_run = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;   // R12: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && tmo < 100000) begin @(negedge clk); tmo++; end
    chk(done == 1'b1, req, "burst ends with done", done, 1);
    repeat (2) @(negedge clk);
    mon_on = 0;
    chk(a_addr.size() == e_addr.size(), req, "strobe count", a_addr.size(), e_addr.size());
    for (int i = 0; i < a_addr.size() && i < e_addr.size(); i++)
      if (a_addr[i] != e_addr[i] || a_idx[i] != e_idx[i]) begin
        bad++; if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      chk(0, req, "address/step trace", a_addr[first_bad] * 100 + a_idx[first_bad],
          e_addr[first_bad] * 100 + e_idx[first_bad]);
    else chk(1, req, "address/step trace", 0, 0);
    bad = 0; first_bad = -1;
    for (int i = 0; i < a_addr.size() && i < e_addr.size(); i++)
      if (!e_first[i] && (a_iv[i] != e_per[i] || a_ce[i] != e_cpv[i])) begin
        bad++; if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      chk(0, "R3", "vector period", a_iv[first_bad], e_per[first_bad]);
    else chk(1, "R3", "vector period", 0, 0);
    chk(err == e_err, req, "err flag", err, e_err);
    chk(busy == 1'b0, req, "idle after burst", busy, 0);
  endtask

  task automatic gen_random();
    for (int i = 0; i < 6; i++) begin
      step_t s;
      int op = int'($urandom % 6);
      int tgt = (i < 5) ? i + 1 + int'($urandom % (5 - i)) : 5;
      int off = int'($urandom % 64) * 4;
      if ($urandom % 25 == 0) off += 2;
      if (i == 5 && (op == 1 || op == 2)) op = 0;
      s = mk(off, 1 + int'($urandom % 3), 20 + 2 * int'($urandom % 3),
             1 + int'($urandom % 3), i == 5, op, int'($urandom % 16), tgt,
             int'($urandom % 3));
      put(i, s);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !vec_stb && !sys_ce && step_idx == '0,
        "R1", "idle after reset", {busy, done, err, vec_stb, sys_ce}, 0);
    for (int i = 0; i < N_STEPS; i++) put(i, '0);

    // R2 R6 plain single step
    put(0, mk(8, 3, 20, 1, 1, 0, 0, 0, 0));
    run_burst("R2", 0, 0, 0, 0, 4'h0, 0);
    // R12 restart ignored while running
    run_burst("R12", 0, 0, 0, 0, 4'h0, 1);
    // R3 multi clocks per vector
    put(0, mk(16, 4, 24, 3, 1, 0, 0, 0, 0));
    run_burst("R3", 0, 0, 0, 0, 4'h0, 0);
    // R4 illegal parameters and legal extremes
    put(0, mk(6, 2, 20, 1, 1, 0, 0, 0, 0));     run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 2, 21, 1, 1, 0, 0, 0, 0));     run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 2, 18, 1, 1, 0, 0, 0, 0));     run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 2, 65552, 1, 1, 0, 0, 0, 0));  run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 2, 20, 0, 1, 0, 0, 0, 0));     run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 0, 20, 1, 1, 0, 0, 0, 0));     run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    put(0, mk(4, 1, 65550, 1, 1, 0, 0, 0, 0));  run_burst("R4", 0, 0, 0, 0, 4'h0, 0);
    // R11 R5 stop on control resource 2, true and inverted
    put(0, mk(0, 1, 20, 1, 0, 4, 9, 0, 0));
    put(1, mk(4, 2, 20, 1, 1, 0, 0, 0, 0));
    run_burst("R11", 0, 0, 0, 0, 4'b0100, 0);
    run_burst("R5", 0, 0, 0, 0, 4'b0000, 0);
    put(0, mk(0, 1, 20, 1, 0, 4, 13, 0, 0));
    run_burst("R5", 0, 0, 0, 0, 4'b0000, 0);
    // R10 loop reload, looping last step
    put(0, mk(0, 2, 20, 2, 0, 3, 0, 0, 2));
    put(1, mk(40, 1, 20, 1, 1, 3, 1, 0, 1));
    run_burst("R10", 1, 0, 0, 0, 4'h0, 0);
    run_burst("R10", 0, 0, 0, 0, 4'h0, 0);
    // R7 jump on fail
    put(0, mk(0, 1, 20, 1, 0, 1, 3, 2, 0));
    put(1, mk(8, 1, 20, 1, 0, 0, 0, 0, 0));
    put(2, mk(12, 1, 22, 2, 1, 0, 0, 0, 0));
    run_burst("R7", 0, 1, 0, 0, 4'h0, 0);
    run_burst("R7", 0, 0, 0, 0, 4'h0, 0);
    // R8 call and return
    put(0, mk(0, 1, 20, 1, 0, 2, 0, 3, 0));
    put(1, mk(20, 1, 20, 1, 1, 0, 0, 0, 0));
    put(3, mk(32, 2, 20, 1, 0, 5, 5, 0, 0));
    run_burst("R8", 0, 0, 1, 0, 4'h0, 0);
    // R8 stack overflow
    for (int i = 0; i < 5; i++) put(i, mk(4 * i, 1, 20, 1, 0, 2, 0, i + 1, 0));
    put(5, mk(64, 1, 20, 1, 1, 0, 0, 0, 0));
    run_burst("R8", 0, 0, 0, 0, 4'h0, 0);
    // R9 return with empty stack
    put(0, mk(0, 1, 20, 1, 0, 5, 0, 0, 0));
    run_burst("R9", 0, 0, 0, 0, 4'h0, 0);
    // R6 op codes 6 and 7 fall through
    put(0, mk(0, 1, 20, 1, 0, 6, 0, 9, 0));
    put(1, mk(4, 1, 20, 1, 1, 7, 0, 9, 0));
    run_burst("R6", 0, 0, 0, 0, 4'h0, 0);
    // R5 constrained random programs
    for (int n = 0; n < 40; n++) begin
      gen_random();
      run_burst("R5", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                4'($urandom), 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule